// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is a small register file reached through one shared write address. An internal phase bit decides what a write does. In the index phase, the written byte selects a register and sets the screen-enable bit. In the data phase, the written byte goes into the selected register. A strobe on a separate status read forces the phase back to index, so software can always resynchronise before a sequence of accesses. Reads use their own strobe and return either the index/phase view or the addressed register. A read never moves the phase.

The file holds 21 byte registers at indices 0x00 to 0x14:
- sixteen palette entries;
- a mode register at 0x10 (bit 3 chooses blink or intensity, bit 7 chooses 16-colour paging);
- an overscan colour at 0x11;
- two general registers at 0x12 and 0x13;
- a 4-bit colour select at 0x14.

The display path receives the stored values and a registered pixel result. While the screen is blanked, that result is the overscan colour. Otherwise it is a 4-bit pixel translated through the palette and combined with the colour-select bits.

Top module: `attr_ctl_port`

## Requirements
- R1: After reset the phase is index, screen enable is 0, the index is 0, all 21 registers are 0, `rd_q` is 0 and `pix_out` is 0.
- R2: A write in the index phase stores bits 4:0 as the index and bit 5 as screen enable, then moves to the data phase.
- R3: A write in the data phase stores the byte in the register at the current index (0x00-0x14) and returns to the index phase. Register 0x14 keeps only bits 3:0; its upper bits read as 0.
- R4: A `stat_rd` strobe forces the phase to index, so the next write is taken as an index.
- R5: A read with `rd_which`=0 loads `rd_q` on the next edge with {phase (1 = data), 0, screen enable, index[4:0]}.
- R6: A read with `rd_which`=1 loads `rd_q` on the next edge with the register at the current index. A read of either kind leaves the phase unchanged.
- R7: A data-phase write to an index 0x15-0x1F changes no register but still returns to the index phase. Reads of such indices return 0.
- R8: While screen enable is 0, `pix_out` equals the overscan register (0x11) one cycle after each edge.
- R9: While screen enable is 1, `pix_out`, one cycle after `pix_in`, is built as follows:
  - bits 3:0 are palette[`pix_in`] bits 3:0;
  - bits 7:6 are colour-select bits 3:2;
  - bits 5:4 are colour-select bits 1:0 when mode bit 7 is 1, else palette bits 5:4.
- R10: `blink_sel` equals mode register bit 3 and `page16` equals mode register bit 7. `mode_q`, `border_q` and `csel_q` show registers 0x10, 0x11 and 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe to the shared index/data address |
| bus_wdata | input | 8 | Write byte |
| stat_rd | input | 1 | Status read strobe; forces the index phase |
| rd_stb | input | 1 | Read strobe |
| rd_which | input | 1 | 0 reads index/phase, 1 reads the addressed register |
| rd_q | output | 8 | Registered read result |
| scr_en | output | 1 | Screen enable (palette source) |
| mode_q | output | 8 | Mode register 0x10 |
| border_q | output | 8 | Overscan register 0x11 |
| csel_q | output | 4 | Colour select register 0x14 |
| blink_sel | output | 1 | Mode bit 3 |
| page16 | output | 1 | Mode bit 7 |
| pix_in | input | 4 | Pixel to translate |
| pix_out | output | 8 | Registered display colour |

## Verification
The phase bit is exercised with three write patterns:
- a plain index-then-data pair;
- an index write followed by a status read, which must turn the next byte into an index;
- data written to indices past 0x14, which must still flip the phase back while storing nothing.

Pixel translation is exercised with blanking, in which the pixel value must not matter, and with paging off and then on. Colour-select and palette bits 5:4 are set to differ, so the output shows which source fed bits 5:4.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int IDX_W      = 5;
  localparam int DW         = 8;
  localparam int NREG       = 21;
  localparam int NPAL       = 16;
  localparam int MODE_IDX   = 16;
  localparam int BORDER_IDX = 17;
  localparam int CSEL_IDX   = 20;

  // Index-port view: phase, spare, screen enable, index
  function automatic logic [DW-1:0] fmt_index(input logic ph, input logic scr,
                                               input logic [IDX_W-1:0] ix);
    return {ph, 1'b0, scr, ix};
  endfunction

  // Palette entry combined with colour select into a display colour
  function automatic logic [DW-1:0] dac_compose(input logic [DW-1:0] ent,
                                                input logic pg16,
                                                input logic [3:0] cs);
    logic [1:0] mid;
    mid = pg16 ? cs[1:0] : ent[5:4];
    return {cs[3:2], mid, ent[3:0]};
  endfunction
endpackage

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
  import attr_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int W  = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          stat_rd,
  output logic          phase_q,
  output logic [IW-1:0] idx_q,
  output logic          scr_q,
  output logic          data_we
);
  localparam int SCR_BIT = IW;

  logic idx_we;
  assign idx_we  = bus_wr && !phase_q;
  assign data_we = bus_wr && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
      scr_q   <= 1'b0;
    end else begin
      if (idx_we) begin
        idx_q <= bus_wdata[IW-1:0];
        scr_q <= bus_wdata[SCR_BIT];
      end
      if (stat_rd)     phase_q <= 1'b0;
      else if (bus_wr) phase_q <= !phase_q;
    end
  end

  a_r4_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase_q);
  a_r2_idx_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && !stat_rd) |=> (phase_q && idx_q == $past(bus_wdata[IW-1:0])));
  a_r3_data_to_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !stat_rd) |=> !phase_q);
  a_r3_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> $stable(idx_q));
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
  import attr_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int W  = DW,
  parameter int N  = NREG,
  parameter int CS = CSEL_IDX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_we,
  input  logic [IW-1:0]      idx,
  input  logic [W-1:0]       wdata,
  output logic [N-1:0][W-1:0] regs,
  output logic               hit,
  output logic [W-1:0]       sel_val
);
  localparam logic [W-1:0] CS_MASK = W'(8'h0F);

  logic [N-1:0] we_vec;
  assign hit     = (32'(idx) < N);
  assign sel_val = hit ? regs[idx] : '0;

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [W-1:0] MASK = (g == CS) ? CS_MASK : '1;
    assign we_vec[g] = data_we && (32'(idx) == g);
    always_ff @(posedge clk) begin
      if (!rst_n)         regs[g] <= '0;
      else if (we_vec[g]) regs[g] <= wdata & MASK;
    end
  end

  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
  a_r7_no_write_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !hit) |=> $stable(regs));
  a_r3_csel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regs[CS][W-1:4] == '0);
endmodule

// File: rtl/attr_pix_map.sv
module attr_pix_map
  import attr_pkg::*;
#(
  parameter int W  = DW,
  parameter int N  = NREG,
  parameter int NP = NPAL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scr,
  input  logic [$clog2(NP)-1:0] pix_in,
  input  logic [N-1:0][W-1:0] regs,
  output logic [W-1:0]       pix_out
);
  localparam int PW = $clog2(NP);

  logic [W-1:0] pal_ent, border, mode_r, lookup;
  logic [3:0]   cs;
  assign pal_ent = regs[{{(5-PW){1'b0}}, pix_in}];
  assign border  = regs[BORDER_IDX];
  assign mode_r  = regs[MODE_IDX];
  assign cs      = regs[CSEL_IDX][3:0];
  assign lookup  = dac_compose(pal_ent, mode_r[7], cs);

  always_ff @(posedge clk) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= scr ? lookup : border;
  end

  a_r8_blank_border: assert property (@(posedge clk) disable iff (!rst_n)
    !scr |=> (pix_out == $past(border)));
  a_r9_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    scr |=> (pix_out[3:0] == $past(pal_ent[3:0])));
endmodule

// File: rtl/attr_ctl_port.sv
module attr_ctl_port
  import attr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       stat_rd,
  input  logic       rd_stb,
  input  logic       rd_which,
  output logic [7:0] rd_q,
  output logic       scr_en,
  output logic [7:0] mode_q,
  output logic [7:0] border_q,
  output logic [3:0] csel_q,
  output logic       blink_sel,
  output logic       page16,
  input  logic [3:0] pix_in,
  output logic [7:0] pix_out
);
  logic                    phase_q, data_we, hit;
  logic [IDX_W-1:0]        idx_q;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           sel_val, idx_view;

  attr_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .stat_rd(stat_rd), .phase_q(phase_q), .idx_q(idx_q), .scr_q(scr_en),
    .data_we(data_we));

  attr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(idx_q),
    .wdata(bus_wdata), .regs(regs), .hit(hit), .sel_val(sel_val));

  attr_pix_map u_pix (
    .clk(clk), .rst_n(rst_n), .scr(scr_en), .pix_in(pix_in),
    .regs(regs), .pix_out(pix_out));

  assign idx_view  = fmt_index(phase_q, scr_en, idx_q);
  assign mode_q    = regs[MODE_IDX];
  assign border_q  = regs[BORDER_IDX];
  assign csel_q    = regs[CSEL_IDX][3:0];
  assign blink_sel = mode_q[3];
  assign page16    = mode_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_stb) rd_q <= rd_which ? sel_val : idx_view;
  end

  a_r6_read_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bus_wr && !stat_rd) |=> $stable(phase_q));
  a_r5_index_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_which) |=> (rd_q[7] == $past(phase_q) && rd_q[5] == $past(scr_en)));
  a_r7_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_which && !hit) |=> (rd_q == 8'h00));
endmodule

// File: tb/sim_attr_ctl_port.sv
module sim_attr_ctl_port;
  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0, stat_rd = 0, rd_stb = 0, rd_which = 0;
  logic [7:0] bus_wdata = 0;
  logic [3:0] pix_in = 0;
  logic [7:0] rd_q, mode_q, border_q, pix_out;
  logic [3:0] csel_q;
  logic       scr_en, blink_sel, page16;
  int total = 0, bad = 0;
  logic [7:0] pal [16];

  always #4 clk = ~clk;

  attr_ctl_port u0 (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] v);
    @(negedge clk); bus_wr = 1; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic do_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic do_rd(input logic w, output logic [7:0] v);
    @(negedge clk); rd_stb = 1; rd_which = w;
    @(negedge clk); rd_stb = 0; v = rd_q;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    do_stat(); do_wr(i); do_wr(v);
  endtask

  function automatic logic [7:0] model_pix(input logic [7:0] e, input logic pg,
                                           input logic [3:0] cs);
    logic [7:0] r;
    r = (8'(cs) >> 2) << 6;
    r = r | ((pg ? (8'(cs) & 8'h3) : ((e >> 4) & 8'h3)) << 4);
    return r | (e & 8'h0F);
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pix_out", pix_out, 8'h00);
    chk("R1 scr_en", {7'b0, scr_en}, 8'h00);
    chk("R1 rd_q", rd_q, 8'h00);
    do_rd(0, v); chk("R1 index view", v, 8'h00);
    do_rd(1, v); chk("R1 reg0", v, 8'h00);
  endtask

  task automatic t_index_data();
    logic [7:0] v;
    do_stat(); do_wr(8'h05);
    do_rd(0, v); chk("R2 R5 data phase view", v, 8'h85);
    do_wr(8'h3A);
    do_rd(0, v); chk("R3 back to index", v, 8'h05);
    do_rd(1, v); chk("R6 data read", v, 8'h3A);
    do_rd(0, v); chk("R6 phase unchanged by read", v, 8'h05);
    do_wr(8'h25);
    do_rd(1, v); chk("R6 read in data phase", v, 8'h3A);
    do_rd(0, v); chk("R2 scr bit in view", v, 8'hA5);
    chk("R2 scr_en", {7'b0, scr_en}, 8'h01);
  endtask

  task automatic t_stat();
    logic [7:0] v;
    do_stat(); do_wr(8'h06);
    do_stat(); do_wr(8'h27);
    do_rd(0, v); chk("R4 stat forces index", v, 8'hA7);
    do_wr(8'h11);
    do_rd(1, v); chk("R4 data after resync", v, 8'h11);
    do_stat(); do_wr(8'h06);
    do_rd(1, v); chk("R4 reg6 untouched", v, 8'h00);
  endtask

  task automatic t_csel();
    logic [7:0] v;
    set_reg(8'h14, 8'hFF);
    do_rd(1, v); chk("R3 csel masked", v, 8'h0F);
    chk("R10 csel_q", {4'b0, csel_q}, 8'h0F);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    set_reg(8'h15, 8'h99);
    do_rd(1, v); chk("R7 unimpl reads zero", v, 8'h00);
    do_rd(0, v); chk("R7 phase back to index", v, 8'h15);
    set_reg(8'h1F, 8'h77);
    do_stat(); do_wr(8'h05);
    do_rd(1, v); chk("R7 reg5 kept", v, 8'h3A);
    do_stat(); do_wr(8'h07);
    do_rd(1, v); chk("R7 reg7 kept", v, 8'h11);
  endtask

  task automatic t_border();
    set_reg(8'h11, 8'h2C);
    chk("R10 border_q", border_q, 8'h2C);
    for (int k = 0; k < 16; k += 5) begin
      @(negedge clk); pix_in = 4'(k);
      @(negedge clk); chk("R8 blank shows border", pix_out, 8'h2C);
    end
  endtask

  task automatic t_lookup();
    for (int k = 0; k < 16; k++) begin
      pal[k] = 8'((k * 37 + 11) & 8'h3F);
      set_reg(8'(k), pal[k]);
    end
    set_reg(8'h14, 8'h0B);
    set_reg(8'h10, 8'h08);
    chk("R10 blink_sel", {7'b0, blink_sel}, 8'h01);
    chk("R10 page16 off", {7'b0, page16}, 8'h00);
    do_stat(); do_wr(8'h20);
    for (int k = 0; k < 16; k += 3) begin
      @(negedge clk); pix_in = 4'(k);
      @(negedge clk); chk("R9 lookup no paging", pix_out, model_pix(pal[k], 1'b0, 4'hB));
    end
    set_reg(8'h10, 8'h80);
    chk("R10 page16 on", {7'b0, page16}, 8'h01);
    chk("R10 mode_q", mode_q, 8'h80);
    do_stat(); do_wr(8'h20);
    for (int k = 1; k < 16; k += 4) begin
      @(negedge clk); pix_in = 4'(k);
      @(negedge clk); chk("R9 lookup paging", pix_out, model_pix(pal[k], 1'b1, 4'hB));
    end
    do_stat(); do_wr(8'h00);
    @(negedge clk);
    chk("R8 blank after disable", pix_out, 8'h2C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index_data();
    t_stat();
    t_csel();
    t_unimpl();
    t_border();
    t_lookup();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule